// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control state machine of a 32-bit RISC datapath that runs each instruction over several clock cycles, reusing one ALU and one memory port. It watches the 6-bit opcode held in the instruction register and the ALU zero flag. Every cycle it drives the strobes that steer the datapath: PC, instruction register, register file and memory writes, multiplexer selects, the kind of immediate extension and the ALU operation.

Five instruction classes are handled, each with its own path through a fixed 4-bit state code. Every instruction first passes through a fetch state and a decode state. Register-register ALU, OR-immediate and store then take two more states. Load takes three more, and branch-if-equal takes one. This gives 4, 4, 4, 5 and 3 cycles per instruction. Two 32-bit counters, one of elapsed cycles and one of completed instructions, let a harness measure the average cycles per instruction of any workload.

Top module: `mc_control`

## Requirements
- R1: While reset is high, at the next clock edge the state becomes 0000 and both counters become zero. In state 0000 no register or memory write strobe is high.
- R2: Fetch (0000) asserts ir_wr and pc_wr, with alu_sel_a=0 (PC), alu_sel_b=01 (constant 4), alu_op=00 (add) and pc_src=0 (ALU result). The next state is decode (0001).
- R3: Decode (0001) uses alu_sel_a=0, alu_sel_b=11 (sign-extended offset shifted left 2), ext_sign=1 and alu_op=00. No write strobe is high. The next state follows the opcode: 0x00 register-register, 0x0D OR-immediate, 0x23 load, 0x2B store, 0x04 branch.
- R4: Register-register runs state 0100 (alu_sel_a=1, alu_sel_b=00 register B, alu_op=10 function field), then state 0101 (reg_wr=1, reg_dst=1 rd, mem_to_reg=0).
- R5: OR-immediate runs state 0110 (alu_sel_a=1, alu_sel_b=10 extended immediate, ext_sign=0 zero extension, alu_op=11 OR), then state 0111 (reg_wr=1, reg_dst=0 rt, mem_to_reg=0).
- R6: Load runs state 1000 (alu_sel_a=1, alu_sel_b=10, ext_sign=1, alu_op=00), then state 1001 (addr_sel=1, the ALUout address, no writes), then state 1010 (reg_wr=1, reg_dst=0, mem_to_reg=1).
- R7: Store runs state 1011 (address as in 1000), then state 1100 (mem_wr=1, addr_sel=1, reg_wr=0).
- R8: Branch state 0010 asserts pc_wr_cond, pc_src=1 (ALUout), alu_sel_a=1, alu_sel_b=00 and alu_op=01 (subtract). pc_wr is high in this state exactly when alu_zero is high.
- R9: Each final state (0010, 0101, 0111, 1010, 1100) is followed by fetch. This gives 4 cycles for register-register, OR-immediate and store, 5 for load and 3 for branch.
- R10: An opcode outside the five listed returns from decode straight to fetch with no write strobe. It is not counted as completed.
- R11: The cycle counter rises by one on every clock edge out of reset. The retire counter rises by one on each edge that leaves a final state. A 40/30/10/20 mix of register-register/load/store/branch thus reads 41 cycles per 10 instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU zero flag |
| pc_wr | output | 1 | PC load enable (fetch, or branch with zero) |
| pc_wr_cond | output | 1 | Conditional PC write marker (branch state) |
| addr_sel | output | 1 | Memory address select: 0 PC, 1 ALUout |
| mem_wr | output | 1 | Memory write |
| ir_wr | output | 1 | Instruction register write |
| pc_src | output | 1 | PC source: 0 ALU result, 1 ALUout |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| reg_wr | output | 1 | Register file write |
| alu_sel_a | output | 1 | ALU A input: 0 PC, 1 register A |
| alu_sel_b | output | 2 | ALU B input: 00 B, 01 four, 10 ext imm, 11 ext imm<<2 |
| ext_sign | output | 1 | Immediate extension: 1 sign, 0 zero |
| mem_to_reg | output | 1 | Write-back source: 0 ALUout, 1 memory data |
| alu_op | output | 2 | ALU operation: 00 add, 01 sub, 10 function, 11 OR |
| state | output | 4 | Current state code |
| cycle_count | output | 32 | Cycles since reset |
| retire_count | output | 32 | Instructions completed since reset |

## Verification
The hardest situation to reach from the ports is a reset that arrives in the middle of a memory-writing state. The write strobe must drop and the counters must clear without the store being counted. The bench steps a store until state 1100 is observed and only then raises reset. It also drives an opcode outside the defined set to show the short decode-to-fetch path. Finally it runs a fixed ten-instruction mix and compares the counter deltas against the expected 41 cycles.

// File: rtl/mc_control.sv
module mc_control #(
  parameter int CW = 32,
  parameter logic [5:0] OP_RR    = 6'h00,
  parameter logic [5:0] OP_ORI   = 6'h0d,
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2b,
  parameter logic [5:0] OP_BEQ   = 6'h04
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [5:0]    opcode,
  input  logic          alu_zero,
  output logic          pc_wr,
  output logic          pc_wr_cond,
  output logic          addr_sel,
  output logic          mem_wr,
  output logic          ir_wr,
  output logic          pc_src,
  output logic          reg_dst,
  output logic          reg_wr,
  output logic          alu_sel_a,
  output logic [1:0]    alu_sel_b,
  output logic          ext_sign,
  output logic          mem_to_reg,
  output logic [1:0]    alu_op,
  output logic [3:0]    state,
  output logic [CW-1:0] cycle_count,
  output logic [CW-1:0] retire_count
);
  localparam logic [3:0] S_FETCH = 4'b0000, S_DEC  = 4'b0001, S_BR   = 4'b0010,
                         S_RREX  = 4'b0100, S_RRWB = 4'b0101, S_OREX = 4'b0110,
                         S_ORWB  = 4'b0111, S_LDAD = 4'b1000, S_LDMM = 4'b1001,
                         S_LDWB  = 4'b1010, S_STAD = 4'b1011, S_STMM = 4'b1100;

  logic [3:0] nxt;
  logic       last;

  always_comb begin
    nxt = S_FETCH;
    case (state)
      S_FETCH: nxt = S_DEC;
      S_DEC: begin
        if      (opcode == OP_RR)    nxt = S_RREX;
        else if (opcode == OP_ORI)   nxt = S_OREX;
        else if (opcode == OP_LOAD)  nxt = S_LDAD;
        else if (opcode == OP_STORE) nxt = S_STAD;
        else if (opcode == OP_BEQ)   nxt = S_BR;
        else                         nxt = S_FETCH;
      end
      S_RREX:  nxt = S_RRWB;
      S_OREX:  nxt = S_ORWB;
      S_LDAD:  nxt = S_LDMM;
      S_LDMM:  nxt = S_LDWB;
      S_STAD:  nxt = S_STMM;
      default: nxt = S_FETCH;
    endcase
  end

  assign last = (state == S_BR) || (state == S_RRWB) || (state == S_ORWB) ||
                (state == S_LDWB) || (state == S_STMM);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= S_FETCH;
      cycle_count  <= '0;
      retire_count <= '0;
    end else begin
      state       <= nxt;
      cycle_count <= cycle_count + 1'b1;
      if (last) retire_count <= retire_count + 1'b1;
    end
  end

  assign ir_wr      = (state == S_FETCH);
  assign pc_wr_cond = (state == S_BR);
  assign pc_wr      = (state == S_FETCH) || (pc_wr_cond && alu_zero);
  assign pc_src     = pc_wr_cond;
  assign addr_sel   = (state == S_LDMM) || (state == S_STMM);
  assign mem_wr     = (state == S_STMM);
  assign reg_wr     = (state == S_RRWB) || (state == S_ORWB) || (state == S_LDWB);
  assign reg_dst    = (state == S_RRWB);
  assign mem_to_reg = (state == S_LDWB);
  assign alu_sel_a  = (state != S_FETCH) && (state != S_DEC);
  assign ext_sign   = (state != S_OREX);

  always_comb begin
    alu_sel_b = 2'b00;
    alu_op    = 2'b00;
    case (state)
      S_FETCH: alu_sel_b = 2'b01;
      S_DEC:   alu_sel_b = 2'b11;
      S_RREX:  alu_op    = 2'b10;
      S_OREX:  begin alu_sel_b = 2'b10; alu_op = 2'b11; end
      S_LDAD, S_STAD: alu_sel_b = 2'b10;
      S_BR:    alu_op    = 2'b01;
      default: ;
    endcase
  end
endmodule

// File: rtl/mc_control_chk.sv
module mc_control_chk #(
  parameter int CW = 32,
  parameter logic [5:0] OP_RR    = 6'h00,
  parameter logic [5:0] OP_ORI   = 6'h0d,
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2b,
  parameter logic [5:0] OP_BEQ   = 6'h04
) (
  input logic          clk,
  input logic          rst,
  input logic [5:0]    opcode,
  input logic          mem_wr,
  input logic          reg_wr,
  input logic          addr_sel,
  input logic          ir_wr,
  input logic [3:0]    state,
  input logic [CW-1:0] cycle_count,
  input logic [CW-1:0] retire_count
);
  logic defined_op;
  assign defined_op = (opcode == OP_RR) || (opcode == OP_ORI) || (opcode == OP_LOAD) ||
                      (opcode == OP_STORE) || (opcode == OP_BEQ);

  // R1
  reset_home_chk: assert property (@(posedge clk) rst |=> (state == 4'b0000 && !mem_wr && !reg_wr && cycle_count == '0));
  // R2
  fetch_to_decode_chk: assert property (@(posedge clk) disable iff (rst) (state == 4'b0000) |=> (state == 4'b0001));
  // R7
  store_addr_chk: assert property (@(posedge clk) disable iff (rst) mem_wr |-> (addr_sel && !reg_wr && !ir_wr));
  // R9
  final_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 4'b0010 || state == 4'b0101 || state == 4'b0111 || state == 4'b1010 || state == 4'b1100)
    |=> (state == 4'b0000 && retire_count == $past(retire_count) + 1'b1));
  // R10
  undef_return_chk: assert property (@(posedge clk) disable iff (rst)
    (state == 4'b0001 && !defined_op) |=> (state == 4'b0000 && retire_count == $past(retire_count)));
  // R11
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> cycle_count == $past(cycle_count) + 1'b1);
endmodule

bind mc_control mc_control_chk #(.CW(CW), .OP_RR(OP_RR), .OP_ORI(OP_ORI), .OP_LOAD(OP_LOAD),
  .OP_STORE(OP_STORE), .OP_BEQ(OP_BEQ)) chk_i (.*);

// File: tb/mc_control_test.sv
module mc_control_test;
  logic clk = 1'b0, rst = 1'b1, alu_zero = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, pc_src, reg_dst, reg_wr, alu_sel_a, ext_sign, mem_to_reg;
  logic [1:0] alu_sel_b, alu_op;
  logic [3:0] state;
  logic [31:0] cycle_count, retire_count;
  int total = 0, bad = 0;

  mc_control uut (.clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero), .pc_wr(pc_wr),
    .pc_wr_cond(pc_wr_cond), .addr_sel(addr_sel), .mem_wr(mem_wr), .ir_wr(ir_wr), .pc_src(pc_src),
    .reg_dst(reg_dst), .reg_wr(reg_wr), .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
    .ext_sign(ext_sign), .mem_to_reg(mem_to_reg), .alu_op(alu_op), .state(state),
    .cycle_count(cycle_count), .retire_count(retire_count));

  always #10 clk = ~clk;

  // {pc_wr,pc_wr_cond,addr_sel,mem_wr,ir_wr,pc_src,reg_dst,reg_wr,alu_sel_a,alu_sel_b,ext_sign,mem_to_reg,alu_op}
  function automatic logic [14:0] want(input logic [3:0] s, input logic z);
    case (s)
      4'b0000: want = 15'b1_0_0_0_1_0_0_0_0_01_1_0_00;
      4'b0001: want = 15'b0_0_0_0_0_0_0_0_0_11_1_0_00;
      4'b0100: want = 15'b0_0_0_0_0_0_0_0_1_00_1_0_10;
      4'b0101: want = 15'b0_0_0_0_0_0_1_1_1_00_1_0_00;
      4'b0110: want = 15'b0_0_0_0_0_0_0_0_1_10_0_0_11;
      4'b0111: want = 15'b0_0_0_0_0_0_0_1_1_00_1_0_00;
      4'b1000, 4'b1011: want = 15'b0_0_0_0_0_0_0_0_1_10_1_0_00;
      4'b1001: want = 15'b0_0_1_0_0_0_0_0_1_00_1_0_00;
      4'b1010: want = 15'b0_0_0_0_0_0_0_1_1_00_1_1_00;
      4'b1100: want = 15'b0_0_1_1_0_0_0_0_1_00_1_0_00;
      4'b0010: want = {z, 14'b1_0_0_0_1_0_0_1_00_1_0_01};
      default: want = 15'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge: check state and strobes, then move to the next negedge
  task automatic look(input string req, input logic [3:0] s);
    chk({req, " state"}, {28'd0, state}, {28'd0, s});
    chk({req, " strobes"}, {17'd0, pc_wr, pc_wr_cond, addr_sel, mem_wr, ir_wr, pc_src, reg_dst, reg_wr,
        alu_sel_a, alu_sel_b, ext_sign, mem_to_reg, alu_op}, {17'd0, want(s, alu_zero)});
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 state", {28'd0, state}, 32'd0);
    chk("R1 cycles", cycle_count, 32'd0);
    chk("R1 retired", retire_count, 32'd0);
    chk("R1 writes", {29'd0, mem_wr, reg_wr, 1'b0}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic run_rr();      opcode = 6'h00; look("R2", 4'b0000); look("R3", 4'b0001); look("R4", 4'b0100); look("R4", 4'b0101); endtask
  task automatic run_ori();     opcode = 6'h0d; look("R2", 4'b0000); look("R3", 4'b0001); look("R5", 4'b0110); look("R5", 4'b0111); endtask
  task automatic run_load();    opcode = 6'h23; look("R2", 4'b0000); look("R3", 4'b0001); look("R6", 4'b1000); look("R6", 4'b1001); look("R6", 4'b1010); endtask
  task automatic run_store();   opcode = 6'h2b; look("R2", 4'b0000); look("R3", 4'b0001); look("R7", 4'b1011); look("R7", 4'b1100); endtask
  task automatic run_br(input logic z); opcode = 6'h04; alu_zero = z; look("R2", 4'b0000); look("R3", 4'b0001); look("R8", 4'b0010); alu_zero = 1'b0; endtask

  task automatic test_classes();
    logic [31:0] c0, r0;
    c0 = cycle_count; r0 = retire_count;
    run_rr(); run_ori(); run_load(); run_store(); run_br(1'b1); run_br(1'b0);
    chk("R9 back to fetch", {28'd0, state}, 32'd0);
    chk("R9 cycle total", cycle_count - c0, 32'd4 + 32'd4 + 32'd5 + 32'd4 + 32'd3 + 32'd3);
    chk("R11 retired", retire_count - r0, 32'd6);
  endtask

  task automatic test_undef();
    logic [31:0] r0;
    r0 = retire_count;
    opcode = 6'h3f;
    look("R10", 4'b0000); look("R10", 4'b0001);
    chk("R10 to fetch", {28'd0, state}, 32'd0);
    chk("R10 not counted", retire_count, r0);
  endtask

  task automatic test_mix();
    logic [31:0] c0, r0;
    c0 = cycle_count; r0 = retire_count;
    for (int i = 0; i < 4; i++) run_rr();
    for (int i = 0; i < 3; i++) run_load();
    run_store();
    run_br(1'b1); run_br(1'b0);
    chk("R11 mix cycles", cycle_count - c0, 32'd41);
    chk("R11 mix retired", retire_count - r0, 32'd10);
  endtask

  task automatic test_reset_store();
    opcode = 6'h2b;
    look("R7", 4'b0000); look("R7", 4'b0001); look("R7", 4'b1011);
    chk("R7 in write", {31'd0, mem_wr}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid reset state", {28'd0, state}, 32'd0);
    chk("R1 mid reset write", {31'd0, mem_wr}, 32'd0);
    chk("R1 mid reset retired", retire_count, 32'd0);
    chk("R1 mid reset cycles", cycle_count, 32'd0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    test_classes();
    test_undef();
    test_mix();
    test_reset_store();
    run_rr();
    chk("R11 after reset", retire_count, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule